// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block sits in front of a synchronous burst memory array. It takes an external address when a new access is strobed, then produces the following addresses of a four-beat burst by itself. It also tracks whether the device is selected. Three chip enables qualify every start: the primary enable is active low, the second is active high and the third is active low. Two address strobes can begin an access. One is a processor-side strobe that only counts while the primary enable is asserted. The other is a controller-side strobe that always acts. With no strobe present, a burst-advance input either steps the burst or suspends it for a wait cycle.

Only the two least significant address bits move during a burst. A static order input picks how they move. LOW gives linear order, where the start value is incremented with wrap. HIGH gives interleaved order, where the start value is XORed with the beat number. The upper address bits stay as captured at the start of the burst. All inputs are sampled on the rising clock edge. Flags mark the first beat of a burst and any wait cycle.

Top module: `bseq_top`

## Requirements
- R1: When every enable is active (`en1_n`=0, `en2`=1, `en3_n`=0) and a strobe is effective at an edge, then after that edge: `addr_out` equals the sampled `addr_in`, `sel`=1, `burst_start`=1 and `wait_cyc`=0. A strobe is effective if it is `strb_c_n`=0, or if it is `strb_p_n`=0 together with `en1_n`=0.
- R2: During a burst, `addr_out[ADDR_W-1:2]` keeps the value captured at the load.
- R3: With `ilv_mode`=0, beat n of a burst that starts at low bits s has `addr_out[1:0]` = (s+n) mod 4.
- R4: With `ilv_mode`=1, beat n of a burst that starts at low bits s has `addr_out[1:0]` = s XOR (n mod 4).
- R5: After the fourth beat, further advances wrap within the same four-address group.
- R6: `strb_p_n`=0 while `en1_n`=1 has no effect. If `strb_c_n`=1 at that edge, `sel` keeps its value and `addr_out` does not change.
- R7: In each of these cases `sel`=0 after the edge: `strb_c_n`=0 with any enable inactive, or `strb_p_n`=0 with `en1_n`=0 while `en2` or `en3_n` is inactive.
- R8: While selected, with no effective strobe and `adv_n`=1, `addr_out` holds and `wait_cyc`=1 after the edge. With `adv_n`=0 the burst steps one beat and `wait_cyc`=0.
- R9: While deselected, with no effective strobe, `adv_n` has no effect: `sel`, `burst_start` and `wait_cyc` stay 0 and `addr_out` holds.
- R10: A synchronous active-high `rst` gives `addr_out`=0, `sel`=0, `burst_start`=0 and `wait_cyc`=0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address |
| en1_n | input | 1 | Primary enable, active low; also gates the processor strobe |
| en2 | input | 1 | Second enable, active high |
| en3_n | input | 1 | Third enable, active low |
| strb_p_n | input | 1 | Processor-side address strobe, active low |
| strb_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current internal address |
| sel | output | 1 | Device selected |
| burst_start | output | 1 | First beat of a freshly loaded burst |
| wait_cyc | output | 1 | Suspended (wait) cycle |

## Verification
The bench builds the block with `ADDR_W`=6. This leaves four upper bits above the two counted bits. The bench can therefore sweep both orders, all four start offsets and contrasting upper patterns (all zeros, all ones, alternating). Each burst runs six beats to cross the wrap, with a wait cycle placed in the middle. The small width also lets the bench compare whole addresses: any leak of the counter into the upper bits shows up in `addr_out`.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_LOAD,
        ACT_DESEL,
        ACT_STEP,
        ACT_HOLD
    } act_e;

    typedef struct packed {
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] cnt;
    } beat_t;

    function automatic logic [BEAT_W-1:0] beat_lsb(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt,
        input logic              interleave
    );
        logic [BEAT_W-1:0] res;
        if (interleave) res = start ^ cnt;
        else            res = start + cnt;
        return res;
    endfunction

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
    import bseq_pkg::*;
(
    input  logic en1_n,
    input  logic en2,
    input  logic en3_n,
    input  logic strb_p_n,
    input  logic strb_c_n,
    input  logic adv_n,
    input  logic sel_q,
    output act_e act
);

    logic all_en;
    logic p_hit;
    logic strobe;

    assign all_en = !en1_n && en2 && !en3_n;
    assign p_hit  = !strb_p_n && !en1_n;
    assign strobe = p_hit || !strb_c_n;

    always_comb begin
        if (strobe)      act = all_en ? ACT_LOAD : ACT_DESEL;
        else if (!sel_q) act = ACT_IDLE;
        else if (adv_n)  act = ACT_HOLD;
        else             act = ACT_STEP;
    end

endmodule

// File: rtl/bseq_counter.sv
module bseq_counter
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic [BEAT_W-1:0] lsb_in,
    output beat_t             beat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    beat_q.start <= lsb_in;
                    beat_q.cnt   <= '0;
                end
                ACT_STEP: beat_q.cnt <= beat_q.cnt + 1'b1;
                default:  beat_q <= beat_q;
            endcase
        end
    end

endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
(
    input  beat_t             beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] lsb
);

    assign lsb = beat_lsb(beat.start, beat.cnt, interleave);

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              strb_p_n,
    input  logic              strb_c_n,
    input  logic              adv_n,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic              sel,
    output logic              burst_start,
    output logic              wait_cyc
);

    localparam int UP_W = ADDR_W - BEAT_W;

    act_e              act;
    beat_t             beat_q;
    logic [BEAT_W-1:0] lsb;
    logic [UP_W-1:0]   upper_q;

    bseq_decode u_dec (
        .en1_n    (en1_n),
        .en2      (en2),
        .en3_n    (en3_n),
        .strb_p_n (strb_p_n),
        .strb_c_n (strb_c_n),
        .adv_n    (adv_n),
        .sel_q    (sel),
        .act      (act)
    );

    bseq_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .lsb_in (addr_in[BEAT_W-1:0]),
        .beat_q (beat_q)
    );

    bseq_order u_ord (
        .beat       (beat_q),
        .interleave (ilv_mode),
        .lsb        (lsb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q     <= '0;
            sel         <= 1'b0;
            burst_start <= 1'b0;
            wait_cyc    <= 1'b0;
        end else begin
            burst_start <= (act == ACT_LOAD);
            wait_cyc    <= (act == ACT_HOLD);
            case (act)
                ACT_LOAD: begin
                    upper_q <= addr_in[ADDR_W-1:BEAT_W];
                    sel     <= 1'b1;
                end
                ACT_DESEL: sel <= 1'b0;
                default:   sel <= sel;
            endcase
        end
    end

    assign addr_out = {upper_q, lsb};

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              en1_n,
    input logic              en2,
    input logic              en3_n,
    input logic              strb_p_n,
    input logic              strb_c_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_out,
    input logic              sel,
    input logic              burst_start,
    input logic              wait_cyc
);

    logic all_en;
    logic no_strobe;
    assign all_en    = !en1_n && en2 && !en3_n;
    assign no_strobe = strb_c_n && (strb_p_n || en1_n);

    // R1
    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        (!strb_c_n && all_en) |=> (sel && burst_start && !wait_cyc && addr_out == $past(addr_in)));

    // R2
    a_r2_upper_hold: assert property (@(posedge clk) disable iff (rst)
        (no_strobe && sel) |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    // R6
    a_r6_pstrobe_ignored: assert property (@(posedge clk) disable iff (rst)
        (!strb_p_n && en1_n && strb_c_n) |=> (sel == $past(sel) && !burst_start));

    // R7
    a_r7_deselect: assert property (@(posedge clk) disable iff (rst)
        (!strb_c_n && !all_en) |=> !sel);

    // R8
    a_r8_wait: assert property (@(posedge clk) disable iff (rst)
        (no_strobe && sel && adv_n) |=> (sel && wait_cyc && !burst_start));

    // R9
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (no_strobe && !sel) |=> (!sel && !burst_start && !wait_cyc));

    // R10
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!sel && !burst_start && !wait_cyc && addr_out == '0));

endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_in     (addr_in),
    .en1_n       (en1_n),
    .en2         (en2),
    .en3_n       (en3_n),
    .strb_p_n    (strb_p_n),
    .strb_c_n    (strb_c_n),
    .adv_n       (adv_n),
    .addr_out    (addr_out),
    .sel         (sel),
    .burst_start (burst_start),
    .wait_cyc    (wait_cyc)
);

// File: tb/sim_bseq_top.sv
`timescale 1ns/1ps
module sim_bseq_top;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          en1_n, en2, en3_n, strb_p_n, strb_c_n, adv_n, ilv_mode;
    logic [AW-1:0] addr_out;
    logic          sel, burst_start, wait_cyc;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    bseq_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
        .ilv_mode(ilv_mode), .addr_out(addr_out), .sel(sel),
        .burst_start(burst_start), .wait_cyc(wait_cyc)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply the inputs, then let one rising edge pass and return at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        strb_p_n = 1'b1; strb_c_n = 1'b1; adv_n = 1'b1;
        en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0;
    endtask

    task automatic flags(input string req, input int s, input int b, input int w);
        check({req, " sel"}, int'(sel), s);
        check({req, " burst_start"}, int'(burst_start), b);
        check({req, " wait_cyc"}, int'(wait_cyc), w);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ups[3];
        int last;
        ups[0] = 0; ups[1] = 15; ups[2] = 10;
        quiet();
        rst = 1'b1; addr_in = '1; ilv_mode = 1'b0;
        @(negedge clk);
        tick();
        // R10: reset state
        check("R10 addr_out", int'(addr_out), 0);
        flags("R10", 0, 0, 0);
        rst = 1'b0;
        tick();
        // R9: still idle after reset release
        flags("R9 after reset", 0, 0, 0);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    int base;
                    int cnt;
                    ilv_mode = m[0];
                    base = ups[u] * 4;
                    quiet();
                    addr_in = AW'(base + s);
                    if (((s + u) % 2) == 0) strb_p_n = 1'b0;
                    else                    strb_c_n = 1'b0;
                    tick();
                    // R1: load
                    check("R1 addr_out", int'(addr_out), base + s);
                    flags("R1", 1, 1, 0);
                    quiet();
                    addr_in = ~addr_in;
                    cnt = 0;
                    for (int n = 1; n <= 6; n++) begin
                        int lsb;
                        if (n == 3) begin
                            adv_n = 1'b1;
                            tick();
                            // R8: suspend holds the address
                            lsb = m ? (s ^ (cnt % 4)) : ((s + cnt) % 4);
                            check("R8 hold addr", int'(addr_out), base + lsb);
                            flags("R8 hold", 1, 0, 1);
                        end
                        adv_n = 1'b0;
                        tick();
                        cnt++;
                        lsb = m ? (s ^ (cnt % 4)) : ((s + cnt) % 4);
                        if (n >= 4)      check("R5 wrap addr", int'(addr_out), base + lsb);
                        else if (m == 1) check("R4 interleaved addr", int'(addr_out), base + lsb);
                        else             check("R3 linear addr", int'(addr_out), base + lsb);
                        // R2: upper bits unchanged
                        check("R2 upper", int'(addr_out[AW-1:2]), ups[u]);
                        flags("R8 step", 1, 0, 0);
                    end
                end
            end
        end

        // R6: processor strobe ignored while primary enable inactive
        last = int'(addr_out);
        quiet();
        en1_n = 1'b1; strb_p_n = 1'b0; addr_in = 6'h15;
        tick();
        check("R6 addr_out", int'(addr_out), last);
        flags("R6 selected", 1, 0, 1);

        // R6: the same while deselected keeps it deselected
        quiet(); en2 = 1'b0; strb_c_n = 1'b0;
        tick();
        // R7: controller strobe with second enable inactive deselects
        flags("R7 en2", 0, 0, 0);
        last = int'(addr_out);
        quiet(); en1_n = 1'b1; strb_p_n = 1'b0; addr_in = 6'h2A;
        tick();
        check("R6 desel addr_out", int'(addr_out), last);
        flags("R6 desel", 0, 0, 0);

        // R9: advance while deselected
        quiet(); adv_n = 1'b0;
        tick();
        tick();
        check("R9 addr_out", int'(addr_out), last);
        flags("R9", 0, 0, 0);

        // R1 via controller strobe, then R7 via processor strobe with third enable off
        quiet(); strb_c_n = 1'b0; addr_in = 6'h26; ilv_mode = 1'b1;
        tick();
        check("R1 reload addr", int'(addr_out), 6'h26);
        flags("R1 reload", 1, 1, 0);
        quiet(); en3_n = 1'b1; strb_p_n = 1'b0;
        tick();
        flags("R7 en3", 0, 0, 0);

        // R7: controller strobe with primary enable inactive
        quiet(); strb_c_n = 1'b0; addr_in = 6'h07;
        tick();
        flags("R1 again", 1, 1, 0);
        quiet(); en1_n = 1'b1; strb_c_n = 1'b0;
        tick();
        flags("R7 en1", 0, 0, 0);

        // R10: reset mid-burst
        quiet(); strb_c_n = 1'b0; addr_in = 6'h3B;
        tick();
        quiet(); rst = 1'b1;
        tick();
        check("R10 mid addr_out", int'(addr_out), 0);
        flags("R10 mid", 0, 0, 0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule